// File: doc/BRIEF.md
# Handshaking Parallel Port Controller

This block is a bidirectional parallel port with handshake lines. A CPU reaches it through a small register bus. Three registers are visible there: a direction register that gives each line its direction, a data register, and a control/status register. Lines marked as outputs drive the value held in the data register. Lines marked as inputs are read either live from the pins or, when latching is enabled, from a snapshot taken on a falling edge of the input strobe.

The input strobe is an asynchronous active-low pin. The block synchronises it into the system clock and detects its falling edges. Each falling edge sets a status flag. When enabled, that flag drives the interrupt output. The flag clears only through a two-step sequence: a status read taken while the flag is set, followed by any access to the data register.

The output strobe is a one-cycle active-low pulse. A control bit selects whether CPU reads or CPU writes of the data register produce it. An external peripheral can use it to learn that data was consumed or supplied.

Top module: `hs_port`

## Requirements
- R1: After reset the direction register, the data register and the control/status register all read 0, pin_oe_o is 0, irq_o is low and stb_out_no is high.
- R2: pin_oe_o equals the direction register (bit 1 means output) and pin_o equals the data register. With latching off, a data-register read returns the data register on output lines and the live pin_i value on input lines.
- R3: A falling edge on stb_in_ni sets the flag, read as control/status bit 7. The flag becomes visible after the third rising clock edge following the pin change. A rising edge of stb_in_ni has no effect.
- R4: The flag clears when a control/status read taken while the flag is set is followed by a data-register read or write. A data-register access that has no such earlier status read leaves the flag set. A status read taken while the flag is clear does not arm the clear.
- R5: irq_o is high exactly when the flag is set and the interrupt enable (control/status bit 6) is set.
- R6: When latch enable (control/status bit 3) is set, a strobe falling edge captures pin_i and closes the latch. While the latch is closed, input lines read the captured value, and further strobe edges do not recapture. A data-register read re-opens the latch. Clearing bit 3 returns input lines to live pins.
- R7: With strobe select (control/status bit 4) clear, a data-register read drives stb_out_no low for exactly the one cycle after the access. With the bit set, a data-register write does so instead. Other accesses leave stb_out_no high.
- R8: Control/status bits 0, 1, 2 and 5 always read 0. A write to bit 7 does not change the flag.
- R9: The register addresses are: 0 direction, 1 data, 2 control/status. Address 3 reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| pin_i | input | DW | Port pin input values |
| pin_o | output | DW | Port pin output values |
| pin_oe_o | output | DW | Per-line output enable |
| stb_in_ni | input | 1 | Asynchronous active-low input strobe |
| stb_out_no | output | 1 | Active-low output strobe pulse |
| irq_o | output | 1 | Strobe interrupt request |

## Verification
The bench uses the defaults DW = 8 and SYNC_STAGES = 2. With these values the split-nibble direction patterns mix output and input lines inside one read. The three-edge strobe latency can also be checked cycle by cycle: the flag must still be clear after two edges and set after the third. With a two-stage synchroniser, strobe pulses held low for four cycles give exactly one detected edge each. This makes it possible to observe the latch holding its snapshot while a second edge arrives.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  typedef enum logic [1:0] {
    A_DIR  = 2'd0,
    A_DATA = 2'd1,
    A_CSR  = 2'd2,
    A_RSVD = 2'd3
  } addr_e;

  localparam int LE_BIT   = 3;
  localparam int OSS_BIT  = 4;
  localparam int IE_BIT   = 6;
  localparam int FLAG_BIT = 7;
  localparam int CSR_W    = 8;
endpackage

// File: rtl/hs_port_sync.sv
module hs_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  // chain_q[STAGES] holds the previous synchronised sample
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

  // R3
  fall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/hs_port_regs.sv
module hs_port_regs #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_wr_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] dir_o,
  output logic [DW-1:0] out_o
);
  logic [DW-1:0] dir_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (dir_wr_i)  dir_q <= wdata_i;
      if (data_wr_i) out_q <= wdata_i;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;

  // R2
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_wr_i |=> $stable(dir_o));
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          csr_wr_i,
  input  logic          csr_rd_i,
  input  logic          data_rd_i,
  input  logic          data_wr_i,
  input  logic          le_w_i,
  input  logic          oss_w_i,
  input  logic          ie_w_i,
  input  logic          fall_i,
  input  logic [DW-1:0] pin_i,
  output logic          le_o,
  output logic          oss_o,
  output logic          ie_o,
  output logic          flag_o,
  output logic          closed_o,
  output logic [DW-1:0] cap_o,
  output logic          irq_o,
  output logic          stb_out_no
);
  logic le_q, oss_q, ie_q, flag_q, armed_q, closed_q, stb_q;
  logic [DW-1:0] cap_q;
  logic data_acc;

  assign data_acc = data_rd_i | data_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q  <= 1'b0;
      oss_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (csr_wr_i) begin
      le_q  <= le_w_i;
      oss_q <= oss_w_i;
      ie_q  <= ie_w_i;
    end
  end

  // flag: set by strobe edge, cleared by status-read then data-access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (fall_i)                   flag_q <= 1'b1;
      else if (data_acc && armed_q) flag_q <= 1'b0;
      if (csr_rd_i)      armed_q <= flag_q;
      else if (data_acc) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      closed_q <= 1'b0;
      cap_q    <= '0;
    end else if (!le_q) begin
      closed_q <= 1'b0;
    end else if (fall_i && (!closed_q || data_rd_i)) begin
      cap_q    <= pin_i;
      closed_q <= 1'b1;
    end else if (data_rd_i) begin
      closed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b1;
    else         stb_q <= ~(oss_q ? data_wr_i : data_rd_i);
  end

  assign le_o       = le_q;
  assign oss_o      = oss_q;
  assign ie_o       = ie_q;
  assign flag_o     = flag_q;
  assign closed_o   = closed_q;
  assign cap_o      = cap_q;
  assign irq_o      = flag_q & ie_q;
  assign stb_out_no = stb_q;

  // R3
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> flag_o);
  // R4
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && armed_q && !fall_i) |=> !flag_o);
  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !fall_i && !(data_acc && armed_q)) |=> flag_o);
  // R8
  csr_wr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && !flag_o && !fall_i) |=> !flag_o);
  // R6
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (closed_o && le_o && !data_rd_i) |=> $stable(cap_o));
  // R7
  ostb_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !oss_o) |=> !stb_out_no);
  // R7
  ostb_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && oss_o) |=> !stb_out_no);
endmodule

// File: rtl/hs_port.sv
module hs_port
  import hs_port_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] pin_oe_o,
  input  logic          stb_in_ni,
  output logic          stb_out_no,
  output logic          irq_o
);
  logic sel_dir, sel_data, sel_csr;
  logic fall;
  logic [DW-1:0] dir, out, cap, in_view, data_view;
  logic le, oss, ie, flag, closed;

  assign sel_dir  = (addr_i == A_DIR);
  assign sel_data = (addr_i == A_DATA);
  assign sel_csr  = (addr_i == A_CSR);

  hs_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(stb_in_ni), .fall_o(fall)
  );

  hs_port_regs #(.DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .dir_wr_i(wr_i & sel_dir), .data_wr_i(wr_i & sel_data),
    .wdata_i(wdata_i), .dir_o(dir), .out_o(out)
  );

  hs_port_ctrl #(.DW(DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .csr_wr_i(wr_i & sel_csr), .csr_rd_i(rd_i & sel_csr),
    .data_rd_i(rd_i & sel_data), .data_wr_i(wr_i & sel_data),
    .le_w_i(wdata_i[LE_BIT]), .oss_w_i(wdata_i[OSS_BIT]), .ie_w_i(wdata_i[IE_BIT]),
    .fall_i(fall), .pin_i(pin_i),
    .le_o(le), .oss_o(oss), .ie_o(ie), .flag_o(flag), .closed_o(closed),
    .cap_o(cap), .irq_o(irq_o), .stb_out_no(stb_out_no)
  );

  assign in_view   = (le && closed) ? cap : pin_i;
  assign data_view = (dir & out) | (~dir & in_view);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DIR:  rdata_o = dir;
      A_DATA: rdata_o = data_view;
      A_CSR: begin
        rdata_o[LE_BIT]   = le;
        rdata_o[OSS_BIT]  = oss;
        rdata_o[IE_BIT]   = ie;
        rdata_o[FLAG_BIT] = flag;
      end
      default: rdata_o = '0;
    endcase
  end

  assign pin_o    = out;
  assign pin_oe_o = dir;

  // R5
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rdata_o[FLAG_BIT] || !sel_csr));
endmodule

// File: tb/hs_port_bench.sv
module hs_port_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic rd_i = 1'b0, wr_i = 1'b0;
  logic [DW-1:0] wdata_i = '0, rdata_o, pin_i = '0, pin_o, pin_oe_o;
  logic stb_in_ni = 1'b1, stb_out_no, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hs_port #(.DW(DW)) u_hs_port (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .stb_in_ni(stb_in_ni), .stb_out_no(stb_out_no),
    .irq_o(irq_o)
  );

  // {dir, out, pins, expected data read}
  localparam logic [31:0] VEC [4] = '{
    32'h00_A5_3C_3C, 32'hFF_A5_3C_A5, 32'hF0_A5_3C_AC, 32'h0F_5A_C3_CA
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr_i = a; rd_i = 1'b1; #1 d = rdata_o;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [DW-1:0] d);
    addr_i = a; #1 d = rdata_o;
  endtask

  task automatic strobe();
    @(negedge clk); stb_in_ni = 1'b0;
    repeat (4) @(negedge clk);
    stb_in_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd2, v); chk("R1 csr", v, 0);
    peek(2'd0, v); chk("R1 dir", v, 0);
    chk("R1 oe", pin_oe_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 stb", stb_out_no, 1);

    // R2 direction vectors
    foreach (VEC[i]) begin
      bus_wr(2'd0, VEC[i][31:24]);
      bus_wr(2'd1, VEC[i][23:16]);
      pin_i = VEC[i][15:8];
      bus_rd(2'd1, v);
      chk("R2 read", v, VEC[i][7:0]);
      chk("R2 oe", pin_oe_o, VEC[i][31:24]);
      chk("R2 out", pin_o, VEC[i][23:16]);
    end

    // R9 reserved address
    bus_wr(2'd3, 8'hFF);
    bus_rd(2'd3, v); chk("R9 rsvd", v, 0);
    peek(2'd0, v); chk("R9 dir kept", v, 8'h0F);

    // R8 unused bits and read-only flag
    bus_wr(2'd2, 8'hFF);
    peek(2'd2, v); chk("R8 csr", v, 8'h58);
    bus_wr(2'd2, 8'h00);
    peek(2'd2, v); chk("R8 clr", v, 8'h00);

    // R3 flag latency and rising-edge immunity
    @(negedge clk); stb_in_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    peek(2'd2, v); chk("R3 early", v[7], 0);
    @(negedge clk);
    peek(2'd2, v); chk("R3 set", v[7], 1);
    repeat (3) @(negedge clk);
    bus_rd(2'd2, v); bus_rd(2'd1, v);
    peek(2'd2, v); chk("R4 cleared", v[7], 0);
    stb_in_ni = 1'b1;
    repeat (5) @(negedge clk);
    peek(2'd2, v); chk("R3 rise", v[7], 0);

    // R4 clear sequence
    strobe();
    bus_rd(2'd1, v);
    peek(2'd2, v); chk("R4 no arm", v[7], 1);
    bus_rd(2'd2, v);
    bus_wr(2'd1, 8'h00);
    peek(2'd2, v); chk("R4 wr clear", v[7], 0);
    bus_rd(2'd2, v);
    strobe();
    bus_rd(2'd1, v);
    peek(2'd2, v); chk("R4 stale arm", v[7], 1);
    bus_rd(2'd2, v); bus_rd(2'd1, v);
    peek(2'd2, v); chk("R4 rd clear", v[7], 0);

    // R5 interrupt
    bus_wr(2'd2, 8'h40);
    chk("R5 no flag", irq_o, 0);
    strobe();
    chk("R5 irq", irq_o, 1);
    bus_wr(2'd2, 8'h00);
    chk("R5 masked", irq_o, 0);
    bus_wr(2'd2, 8'h40);
    chk("R5 unmask", irq_o, 1);
    bus_rd(2'd2, v); bus_rd(2'd1, v);
    chk("R5 cleared", irq_o, 0);
    bus_wr(2'd2, 8'h00);

    // R6 input latch
    bus_wr(2'd0, 8'h0F);
    bus_wr(2'd1, 8'h05);
    bus_wr(2'd2, 8'h08);
    pin_i = 8'h9A;
    strobe();
    pin_i = 8'h61;
    peek(2'd1, v); chk("R6 captured", v, 8'h95);
    strobe();
    peek(2'd1, v); chk("R6 no recapture", v, 8'h95);
    bus_rd(2'd1, v); chk("R6 rd", v, 8'h95);
    peek(2'd1, v); chk("R6 reopened", v, 8'h65);
    strobe();
    pin_i = 8'hE0;
    peek(2'd1, v); chk("R6 recapture", v, 8'h65);
    bus_wr(2'd2, 8'h00);
    peek(2'd1, v); chk("R6 disabled", v, 8'hE5);

    // R7 output strobe
    @(negedge clk);
    bus_rd(2'd1, v); chk("R7 rd pulse", stb_out_no, 0);
    @(negedge clk); chk("R7 one cycle", stb_out_no, 1);
    bus_wr(2'd1, 8'h00); chk("R7 wr quiet", stb_out_no, 1);
    bus_wr(2'd2, 8'h10);
    bus_wr(2'd1, 8'h11); chk("R7 wr pulse", stb_out_no, 0);
    @(negedge clk); chk("R7 one cycle wr", stb_out_no, 1);
    bus_rd(2'd1, v); chk("R7 rd quiet", stb_out_no, 1);
    bus_rd(2'd2, v); chk("R7 csr quiet", stb_out_no, 1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule